// File: doc/BRIEF.md
# Load/Store Byte-Lane Steering Unit

This block connects the load/store stage of a 32-bit processor to a 32-bit data bus whose byte lanes are fixed. The block takes one operation at a time: a store or a load, a size code (byte, halfword or word), the two low address bits and, for stores, the register value. For a store, it drives the byte enables and moves the low register bytes onto the lanes that the address offset selects. For a load, it takes the bus word, moves the addressed lanes down to the low end of the result and extends the value with zeros or with its sign.

Each transfer takes exactly one bus access. A size that does not fit its offset is rejected with an error pulse, and no bus cycle starts. The request is held stable until the bus acknowledges it. The load result is captured on the acknowledge edge and is shown with a one-cycle valid strobe. A new operation is taken only while no transfer is pending.

Top module: `lsu_lane_steer`

## Requirements
- R1: A byte transfer (size code 00) at offset 0, 1, 2 or 3 drives byte enables 0001, 0010, 0100 or 1000 respectively. Enable bit n guards bus bits [8n+7:8n].
- R2: A halfword transfer (size code 01) is legal only at offset 0, with enables 0011, or at offset 2, with enables 1100.
- R3: A word transfer (size code 10) is legal only at offset 0 and drives enables 1111.
- R4: On a store, register byte k (bits [8k+7:8k]) appears on lane offset+k for every byte of the transfer. A byte store uses register bits [7:0], a halfword store uses bits [15:0] and a word store passes all 32 bits in place.
- R5: During a store, every lane whose enable is low carries zero.
- R6: On a load, bus lane offset+k lands in result byte k. A byte load fills result bits [7:0], a halfword load fills bits [15:0] and a word load fills all 32 bits.
- R7: For byte and halfword loads, the bits of the result above the loaded data are zero when op_unsigned is 1. When op_unsigned is 0, they are copies of result bit 7 (byte) or bit 15 (halfword).
- R8: An operation is misaligned if it is a halfword at an odd offset, a word at a nonzero offset, or uses size code 11. Such an operation raises misalign for exactly one cycle, in the cycle after it is accepted, and issues no bus request.
- R9: An accepted legal operation raises bus_req on the next cycle. bus_req, bus_we, bus_be and bus_wdata then stay unchanged until the cycle in which bus_ack is sampled high. op_ready is low throughout, and operations offered during that time are ignored.
- R10: A load's result is captured from bus_rdata on the acknowledge edge. ld_valid is high for exactly the following cycle. A store never raises ld_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered by the pipeline |
| op_ready | output | 1 | High when no transfer is pending; an operation is accepted when op_valid and op_ready are both high |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| op_unsigned | input | 1 | Zero-extend a load result when high |
| op_off | input | 2 | Low two address bits |
| op_wdata | input | 32 | Register value to store |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_be | output | 4 | Byte enables, bit n for bus bits [8n+7:8n] |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ack | input | 1 | Bus acknowledges the pending request |
| bus_rdata | input | 32 | Bus read word, valid with bus_ack |
| ld_valid | output | 1 | One-cycle strobe for the load result |
| ld_data | output | 32 | Aligned and extended load result |
| misalign | output | 1 | One-cycle error pulse for a rejected operation |

## Verification
The assertions check the following on every cycle:
- the number of enables is 1, 2 or 4 and their position fits the transfer size;
- lanes that are not enabled carry zero during a store;
- the request holds still until it is acknowledged;
- ld_valid is a single-cycle strobe that follows an acknowledged load;
- misalign never coincides with a bus request.

Only the bench scenarios can show the following:
- which exact lane each register byte lands on, for every size and offset;
- the values of the aligned, sign-extended and zero-extended load results;
- that operations offered while a transfer is pending are dropped.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/lane_be_gen.sv
module lane_be_gen #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lane_pkg::xfer_size_e size,
    input  logic [OFF_W-1:0]     off,
    output logic [LANES-1:0]     be,
    output logic                 bad
);
    int nbytes;

    always_comb begin
        nbytes = 1 << int'(size);
        bad = (size == lane_pkg::SZ_BAD) || (nbytes > LANES) ||
              ((int'(off) & (nbytes - 1)) != 0);
    end

    for (genvar n = 0; n < LANES; n++) begin : g_be
        assign be[n] = !bad && (n >= int'(off)) && (n < int'(off) + nbytes);
    end
endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW = 8 * LANES
) (
    input  logic [DW-1:0]    reg_val,
    input  logic [OFF_W-1:0] off,
    input  logic [LANES-1:0] be,
    output logic [DW-1:0]    lanes
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [OFF_W-1:0] src_d;
        assign src_d = OFF_W'(n) - off;
        assign lanes[8*n +: 8] = be[n] ? reg_val[8*int'(src_d) +: 8] : 8'h00;
    end
endmodule

// File: rtl/lane_rd_align.sv
module lane_rd_align #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW = 8 * LANES
) (
    input  logic [DW-1:0]        rdata,
    input  logic [OFF_W-1:0]     off,
    input  lane_pkg::xfer_size_e size,
    input  logic                 uns,
    output logic [DW-1:0]        result
);
    int   nb;
    logic sgn;

    always_comb begin
        nb = (size == lane_pkg::SZ_BAD) ? LANES : (1 << int'(size));
        if (nb > LANES) nb = LANES;
        result = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < nb) result[8*k +: 8] = rdata[8*int'(off + OFF_W'(k)) +: 8];
        end
        sgn = result[8*nb-1] & !uns;
        for (int k = 0; k < LANES; k++) begin
            if (k >= nb) result[8*k +: 8] = {8{sgn}};
        end
    end
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic [1:0]        op_size,
    input  logic              op_unsigned,
    input  logic [OFF_W-1:0]  op_off,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);
    import lane_pkg::*;

    typedef struct packed {
        logic              req;
        logic              we;
        logic              uns;
        xfer_size_e        size;
        logic [OFF_W-1:0]  off;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              ld_valid;
        logic [DATA_W-1:0] ld_data;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    xfer_size_e        in_size;
    logic [LANES-1:0]  be_new;
    logic              bad_new;
    logic [DATA_W-1:0] wd_new;
    logic [DATA_W-1:0] ld_new;

    assign in_size = xfer_size_e'(op_size);

    lane_be_gen #(.LANES(LANES)) u_be (
        .size (in_size),
        .off  (op_off),
        .be   (be_new),
        .bad  (bad_new)
    );

    lane_wr_steer #(.LANES(LANES)) u_wr (
        .reg_val (op_wdata),
        .off     (op_off),
        .be      (be_new),
        .lanes   (wd_new)
    );

    lane_rd_align #(.LANES(LANES)) u_rd (
        .rdata  (bus_rdata),
        .off    (st_q.off),
        .size   (st_q.size),
        .uns    (st_q.uns),
        .result (ld_new)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ld_valid = 1'b0;
        st_d.err      = 1'b0;
        if (st_q.req) begin
            if (bus_ack) begin
                st_d.req = 1'b0;
                if (!st_q.we) begin
                    st_d.ld_valid = 1'b1;
                    st_d.ld_data  = ld_new;
                end
            end
        end else if (op_valid) begin
            if (bad_new) begin
                st_d.err = 1'b1;
            end else begin
                st_d.req   = 1'b1;
                st_d.we    = op_store;
                st_d.uns   = op_unsigned;
                st_d.size  = in_size;
                st_d.off   = op_off;
                st_d.be    = be_new;
                st_d.wdata = op_store ? wd_new : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_ready  = !st_q.req;
    assign bus_req   = st_q.req;
    assign bus_we    = st_q.we;
    assign bus_be    = st_q.req ? st_q.be : '0;
    assign bus_wdata = st_q.req ? st_q.wdata : '0;
    assign ld_valid  = st_q.ld_valid;
    assign ld_data   = st_q.ld_data;
    assign misalign  = st_q.err;

    logic [DATA_W-1:0] lane_mask;
    always_comb begin
        for (int n = 0; n < LANES; n++) lane_mask[8*n +: 8] = {8{bus_be[n]}};
    end

    // R1 R2 R3
    be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == (1 << int'(st_q.size))));

    // R2 R3
    be_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((int'(st_q.off) & ((1 << int'(st_q.size)) - 1)) == 0));

    // R5
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> ((bus_wdata & ~lane_mask) == '0));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_be) &&
                                   $stable(bus_wdata) && $stable(bus_we)));

    // R10
    ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R10
    ld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(bus_req && bus_ack && !bus_we));

    // R8
    err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!bus_req && !$past(bus_req)));
endmodule

// File: tb/sim_lsu_lane_steer.sv
module sim_lsu_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_store = 1'b0, op_unsigned = 1'b0;
    logic [1:0]  op_size = 2'b00, op_off = 2'b00;
    logic [31:0] op_wdata = '0;
    logic        op_ready, bus_req, bus_we, ld_valid, misalign;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, ld_data;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    lsu_lane_steer u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_store(op_store), .op_size(op_size), .op_unsigned(op_unsigned),
        .op_off(op_off), .op_wdata(op_wdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .misalign(misalign)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'b00: return 4'b0001 << off;
            2'b01: return (off == 2'd0) ? 4'b0011 : (off == 2'd2) ? 4'b1100 : 4'b0000;
            2'b10: return (off == 2'd0) ? 4'b1111 : 4'b0000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [1:0] off,
                                           input logic [31:0] d);
        case (sz)
            2'b00: return {24'h0, d[7:0]} << (8 * off);
            2'b01: return {16'h0, d[15:0]} << (8 * off);
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] off,
                                           input logic u, input logic [31:0] r);
        logic [31:0] s;
        s = r >> (8 * off);
        case (sz)
            2'b00: return u ? {24'h0, s[7:0]} : {{24{s[7]}}, s[7:0]};
            2'b01: return u ? {16'h0, s[15:0]} : {{16{s[15]}}, s[15:0]};
            default: return r;
        endcase
    endfunction

    task automatic run_op(input logic st, input logic [1:0] sz, input logic [1:0] off,
                          input logic u, input logic [31:0] wd, input logic [31:0] rd,
                          input int dly);
        logic [3:0]  be_e;
        logic [31:0] wd_e;
        be_e = exp_be(sz, off);
        @(negedge clk);
        op_valid = 1'b1; op_store = st; op_size = sz; op_off = off;
        op_unsigned = u; op_wdata = wd; bus_ack = 1'b0;
        @(negedge clk);
        if (be_e == 4'b0000) begin
            op_valid = 1'b0;
            chk(misalign == 1'b1, "R8 misalign pulse", 32'(misalign), 32'd1);
            chk(bus_req == 1'b0, "R8 no request", 32'(bus_req), 32'd0);
            @(negedge clk);
            chk(misalign == 1'b0, "R8 single cycle", 32'(misalign), 32'd0);
            return;
        end
        chk(bus_req == 1'b1 && op_ready == 1'b0, "R9 request raised",
            {30'h0, bus_req, op_ready}, 32'd2);
        chk(bus_be == be_e, "R1 R2 R3 enables", 32'(bus_be), 32'(be_e));
        chk(bus_we == st, "R9 direction", 32'(bus_we), 32'(st));
        if (st) begin
            wd_e = exp_wd(sz, off, wd);
            chk(bus_wdata == wd_e, "R4 R5 store lanes", bus_wdata, wd_e);
        end
        op_store = ~st; op_size = $urandom_range(0, 3); op_off = $urandom_range(0, 3);
        op_wdata = $urandom;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(bus_req == 1'b1 && bus_be == be_e, "R9 hold until ack",
                {27'h0, bus_req, bus_be}, {27'h0, 1'b1, be_e});
        end
        bus_ack = 1'b1; bus_rdata = rd;
        @(negedge clk);
        bus_ack = 1'b0; op_valid = 1'b0; bus_rdata = $urandom;
        chk(bus_req == 1'b0, "R9 released and extra ops ignored", 32'(bus_req), 32'd0);
        chk(ld_valid == !st, "R10 ld_valid after ack", 32'(ld_valid), 32'(!st));
        if (!st) begin
            wd_e = exp_ld(sz, off, u, rd);
            chk(ld_data == wd_e, "R6 R7 load result", ld_data, wd_e);
        end
        @(negedge clk);
        chk(ld_valid == 1'b0 && bus_req == 1'b0, "R10 single pulse",
            {30'h0, ld_valid, bus_req}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(bus_req == 0 && ld_valid == 0 && misalign == 0 && op_ready == 1,
            "R9 reset state", {28'h0, bus_req, ld_valid, misalign, op_ready}, 32'd1);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int w = 0; w < 2; w++)
                    for (int u = 0; u < 2; u++)
                        run_op(w[0], s[1:0], o[1:0], u[0], 32'hA1B2C3D4,
                               32'h8F7E_F180, (s + o) % 3);
        run_op(1'b0, 2'b00, 2'd3, 1'b0, '0, 32'h8000_0000, 0);  // R7 sign byte
        run_op(1'b0, 2'b00, 2'd3, 1'b1, '0, 32'h8000_0000, 0);  // R7 zero byte
        run_op(1'b0, 2'b01, 2'd2, 1'b0, '0, 32'h8001_7FFF, 1);  // R7 sign half
        run_op(1'b0, 2'b01, 2'd0, 1'b0, '0, 32'h8001_7FFF, 1);  // R7 positive half
        run_op(1'b1, 2'b10, 2'd0, 1'b0, 32'hFFFF_FFFF, '0, 2);  // R4 full word
        for (int i = 0; i < 300; i++)
            run_op($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 3));
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule